// File: doc/BRIEF.md
# Variable-Width CRC32 Frame Engine

This block accumulates a 32-bit cyclic redundancy check over a frame that arrives as 32-bit words. Each word may carry one to four valid bytes, and a 3-bit byte-count code says how many. Valid bytes always sit at the most significant end of the word. The same engine serves a transmitter that generates a check value and a receiver that recomputes one. Comparing the result against a received value is left to the surrounding logic.

A one-cycle `frame_init` pulse at the start of every frame loads the running remainder with the parameter `INIT_VAL`. The calculation is cumulative from that point, so a frame without this pulse continues from the previous frame's state. The remainder register keeps the raw polynomial division state, and the next beat always works from that raw value. The `crc_o` output is a separate view of the register: every bit inverted and the four bytes swapped end for end. After the last valid word of a frame, `crc_o` is the check value for the whole frame.

The input stream uses valid/ready. `in_ready` is high at all times, so the block never applies back-pressure, and a beat transfers on every clock edge where `in_valid` is high.

Top module: `crc32_frame_engine`

## Requirements
- R1: While `frame_init` is high at a clock edge, the remainder loads `INIT_VAL`. From that edge on, `crc_o` shows `INIT_VAL` with all bits inverted and its bytes reversed, until the next accepted beat. With the default `INIT_VAL` of 32'hFFFFFFFF, this view is 32'h00000000.
- R2: An accepted beat with code 3'b011 folds all four bytes into the remainder. The order is bits [31:24], [23:16], [15:8], then [7:0], each byte most significant bit first, with generator 32'h04C11DB7. The result appears on `crc_o` after that edge.
- R3: Code 3'b000 uses only bits [31:24], 3'b001 uses bits [31:16], and 3'b010 uses bits [31:8]. The bits below the used bytes have no effect on the result. Codes 3'b100 to 3'b111 act like 3'b011.
- R4: When `in_valid` is low and `frame_init` is low, the remainder and `crc_o` hold their values, whatever `in_data` and `in_bytes` carry.
- R5: When `frame_init` and `in_valid` are both high at the same edge, the remainder loads `INIT_VAL` and the data is discarded.
- R6: Across several beats the result is cumulative. For the bytes "123456789", sent as two full words and one single-byte word, `crc_o` ends at 32'h181989FC. This is the inverted, byte-reversed form of 32'h0376E6E7.
- R7: `INIT_VAL` may be set to 32'h52325032. After `frame_init`, such an instance shows 32'hCDAFCDAD on `crc_o`.
- R8: The active-low asynchronous `rst_n` loads the remainder with `INIT_VAL`. `in_ready` is high whenever the block is clocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; loads the initial value |
| frame_init | input | 1 | Start-of-frame load of the initial value; wins over data |
| in_valid | input | 1 | Data beat present |
| in_ready | output | 1 | Beat can be accepted (always high) |
| in_data | input | 32 | Data word; valid bytes start at bit 31 |
| in_bytes | input | 3 | Valid byte count minus one |
| crc_o | output | 32 | Inverted, byte-reversed view of the remainder |

## Verification
The assertions assume that `rst_n` stays low for at least one clock edge before any beat. They also assume that `frame_init`, `in_valid` and `in_bytes` are known values at every edge once reset is released. Within those limits, they check that the output only moves after an accepted beat or a load, that it holds through idle cycles, and that a load always wins. The stimulus drives every input on the falling edge from reset onward and never leaves any of them undriven. It mixes random frames, random idle gaps and random junk in the unused low bytes with directed vectors. The byte-count codes are drawn from 3'b000 to 3'b011, which covers every width the protocol defines.

// File: rtl/crc32_pkg.sv
package crc32_pkg;
  localparam int unsigned CRC_W  = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = CRC_W / BYTE_W;
  localparam logic [CRC_W-1:0] GEN_POLY = 32'h04C11DB7;

  // Advance the raw remainder by one byte, most significant bit first.
  function automatic logic [CRC_W-1:0] crc_fold_byte(input logic [CRC_W-1:0] rem,
                                                     input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = rem;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ b[i];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? GEN_POLY : '0);
    end
    return r;
  endfunction

  // Presentation form: invert every bit and swap byte order.
  function automatic logic [CRC_W-1:0] crc_present(input logic [CRC_W-1:0] rem);
    logic [CRC_W-1:0] o;
    for (int k = 0; k < LANES; k++)
      o[k*BYTE_W +: BYTE_W] = ~rem[(LANES-1-k)*BYTE_W +: BYTE_W];
    return o;
  endfunction
endpackage

// File: rtl/crc32_byte_stage.sv
module crc32_byte_stage
  import crc32_pkg::*;
(
  input  logic [CRC_W-1:0]  rem_in,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [CRC_W-1:0]  rem_out
);
  always_comb rem_out = crc_fold_byte(rem_in, byte_in);
endmodule

// File: rtl/crc32_lane_chain.sv
module crc32_lane_chain
  import crc32_pkg::*;
#(
  parameter int unsigned NLANES = LANES,
  localparam int unsigned SEL_W = $clog2(NLANES)
)(
  input  logic [CRC_W-1:0]          rem_in,
  input  logic [NLANES*BYTE_W-1:0]  word_in,
  input  logic [SEL_W-1:0]          last_lane,
  output logic [CRC_W-1:0]          rem_out
);
  // tap[k+1] is the remainder after lanes 0..k (lane 0 = most significant byte)
  logic [CRC_W-1:0] tap [NLANES+1];
  assign tap[0] = rem_in;

  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    crc32_byte_stage u_stage (
      .rem_in  (tap[k]),
      .byte_in (word_in[(NLANES-1-k)*BYTE_W +: BYTE_W]),
      .rem_out (tap[k+1])
    );
  end

  always_comb begin
    rem_out = tap[NLANES];
    for (int k = 0; k < NLANES; k++)
      if (last_lane == SEL_W'(k)) rem_out = tap[k+1];
  end
endmodule

// File: rtl/crc32_out_view.sv
module crc32_out_view
  import crc32_pkg::*;
(
  input  logic [CRC_W-1:0] rem,
  output logic [CRC_W-1:0] view
);
  for (genvar k = 0; k < LANES; k++) begin : g_swap
    assign view[k*BYTE_W +: BYTE_W] = ~rem[(LANES-1-k)*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/crc32_frame_engine.sv
module crc32_frame_engine
  import crc32_pkg::*;
#(
  parameter logic [31:0] INIT_VAL = 32'hFFFFFFFF,
  localparam int unsigned SEL_W = $clog2(LANES)
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_init,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic [2:0]  in_bytes,
  output logic [31:0] crc_o
);
  logic [CRC_W-1:0] rem_q;
  logic [CRC_W-1:0] rem_next;
  logic [SEL_W-1:0] last_lane;

  assign in_ready = 1'b1;

  // codes above the widest lane saturate to a full word
  always_comb last_lane = in_bytes[2] ? SEL_W'(LANES - 1) : in_bytes[SEL_W-1:0];

  crc32_lane_chain #(.NLANES(LANES)) u_chain (
    .rem_in    (rem_q),
    .word_in   (in_data),
    .last_lane (last_lane),
    .rem_out   (rem_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     rem_q <= INIT_VAL;
    else if (frame_init)            rem_q <= INIT_VAL;
    else if (in_valid && in_ready)  rem_q <= rem_next;
  end

  crc32_out_view u_view (
    .rem  (rem_q),
    .view (crc_o)
  );
endmodule

// File: rtl/crc32_frame_engine_chk.sv
module crc32_frame_engine_chk
  import crc32_pkg::*;
#(
  parameter logic [31:0] INIT_VAL = 32'hFFFFFFFF
)(
  input logic        clk,
  input logic        rst_n,
  input logic        frame_init,
  input logic        in_valid,
  input logic [31:0] crc_o
);
  a_r1_init_view: assert property (@(posedge clk) disable iff (!rst_n)
    frame_init && !in_valid |=> crc_o == crc_present(INIT_VAL));

  a_r5_init_wins: assert property (@(posedge clk) disable iff (!rst_n)
    frame_init && in_valid |=> crc_o == crc_present(INIT_VAL));

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_init && !in_valid |=> $stable(crc_o));

  a_r2_moves_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$stable(crc_o) |-> $past(in_valid) || $past(frame_init));
endmodule

bind crc32_frame_engine crc32_frame_engine_chk #(.INIT_VAL(INIT_VAL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_init (frame_init),
  .in_valid   (in_valid),
  .crc_o      (crc_o)
);

// File: tb/crc32_frame_engine_tb_top.sv
module crc32_frame_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_init = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic [2:0]  in_bytes = '0;
  logic        in_ready, sata_ready;
  logic [31:0] crc_o, sata_crc;

  int total = 0;
  int bad = 0;
  logic [31:0] model;

  always #5 clk = ~clk;

  crc32_frame_engine dut_i (
    .clk(clk), .rst_n(rst_n), .frame_init(frame_init), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_bytes(in_bytes), .crc_o(crc_o));

  crc32_frame_engine #(.INIT_VAL(32'h52325032)) dut_sata (
    .clk(clk), .rst_n(rst_n), .frame_init(frame_init), .in_valid(in_valid),
    .in_ready(sata_ready), .in_data(in_data), .in_bytes(in_bytes), .crc_o(sata_crc));

  // bit-serial reference, written from R2/R3
  function automatic logic [31:0] ref_beat(logic [31:0] r, logic [31:0] d, logic [2:0] code);
    int n;
    logic fb;
    n = code[2] ? 4 : int'(code[1:0]) + 1;
    for (int bi = 31; bi >= 32 - 8*n; bi--) begin
      fb = r[31] ^ d[bi];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_view(logic [31:0] r);
    logic [31:0] x;
    x = ~r;
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // drive at falling edge, let one rising edge pass, return at next falling edge
  task automatic step(logic init, logic v, logic [31:0] d, logic [2:0] c);
    frame_init = init; in_valid = v; in_data = d; in_bytes = c;
    if (init) model = 32'hFFFFFFFF;
    else if (v) model = ref_beat(model, d, c);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] keep;
    void'($urandom(32'd7031));
    model = 32'hFFFFFFFF;
    @(negedge clk); @(negedge clk);
    check("R8 reset view", crc_o, 32'h00000000);
    check("R8 ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 and R7: load view
    step(1, 0, 32'h0, 3'd0);
    check("R1 init view", crc_o, 32'h00000000);
    check("R7 sata init view", sata_crc, 32'hCDAFCDAD);

    // R6 known vector "123456789"
    step(0, 1, 32'h31323334, 3'd3);
    step(0, 1, 32'h35363738, 3'd3);
    step(0, 1, 32'h39AABBCC, 3'd0);
    check("R6 known vector", crc_o, 32'h181989FC);
    check("R6 model agree", crc_o, ref_view(model));

    // R4 idle with junk holds
    keep = crc_o;
    step(0, 0, 32'hDEADBEEF, 3'd3);
    step(0, 0, 32'h12345678, 3'd1);
    check("R4 idle hold", crc_o, keep);

    // R3 low bytes ignored, each short code
    for (int c = 0; c < 3; c++) begin
      logic [31:0] hi, a, b;
      hi = $urandom;
      step(1, 0, 0, 0);
      step(0, 1, hi, 3'(c));
      a = crc_o;
      check("R3 short width vs model", a, ref_view(model));
      step(1, 0, 0, 0);
      step(0, 1, (hi & ~(32'hFFFFFFFF >> (8*(c+1)))) | ($urandom >> (8*(c+1))), 3'(c));
      b = crc_o;
      check("R3 low bytes ignored", b, a);
    end

    // R3 saturating codes equal full word
    step(1, 0, 0, 0);
    step(0, 1, 32'hCAFEF00D, 3'd6);
    check("R3 code 110 as full", crc_o, ref_view(ref_beat(32'hFFFFFFFF, 32'hCAFEF00D, 3'd3)));

    // R5 init wins over data
    step(0, 1, 32'h01020304, 3'd3);
    step(1, 1, 32'hFFFF0000, 3'd3);
    check("R5 init wins", crc_o, 32'h00000000);

    // R2 random frames with gaps
    for (int f = 0; f < 60; f++) begin
      int len;
      step(1, 0, $urandom, 3'($urandom % 4));
      len = 1 + ($urandom % 12);
      for (int w = 0; w < len; w++) begin
        if ($urandom % 4 == 0) begin
          keep = crc_o;
          step(0, 0, $urandom, 3'($urandom % 4));
          check("R4 gap hold", crc_o, keep);
        end
        step(0, 1, $urandom, (w == len-1) ? 3'($urandom % 4) : 3'd3);
        check("R2 random beat", crc_o, ref_view(model));
      end
    end

    // R8 async reset mid-frame
    step(0, 1, 32'h55AA55AA, 3'd3);
    rst_n = 1'b0;
    #1;
    check("R8 async reset", crc_o, 32'h00000000);
    check("R8 async reset sata", sata_crc, 32'hCDAFCDAD);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule